// File: doc/BRIEF.md
# Signed 16-bit ALU with flags

This block is a purely combinational arithmetic unit. It works on two 16-bit two's-complement operands and a 3-bit operation code. It computes the sum, the difference, the product and both operand passthroughs at the same time. A result selector then drives the one that the code names onto the 16-bit result.

Three status bits come with every result. Bit 2 reports signed overflow of the chosen operation. Bit 1 is high when the result is zero. Bit 0 is high when the result is negative. The subtractor reuses the adder: it inverts the second operand and forces the carry-in to one. The multiplier forms the full 32-bit product and keeps its low half. Any unused operation code gives a zero result.

Top module: `alu16_flags`

## Requirements
- R1: Code 3'b000 drives the low 16 bits of a_in + b_in onto res_out.
- R2: Code 3'b100 drives the low 16 bits of a_in - b_in onto res_out.
- R3: Code 3'b001 drives the low 16 bits of the full signed product a_in * b_in onto res_out.
- R4: Code 3'b010 drives a_in onto res_out, and code 3'b011 drives b_in onto res_out.
- R5: Codes 3'b101, 3'b110 and 3'b111 drive res_out to all zeros.
- R6: For codes 3'b000 and 3'b100, flags_out[2] is high exactly when the true signed sum or difference lies outside -32768..32767. For example, -32768 + -32768 gives res_out = 0 with flags_out[2] = 1 and flags_out[1] = 1.
- R7: For code 3'b001, flags_out[2] is high exactly when the full signed product lies outside -32768..32767. For example, -32768 * -1 sets it.
- R8: For codes 3'b010, 3'b011, 3'b101, 3'b110 and 3'b111, flags_out[2] is 0.
- R9: flags_out[1] is high exactly when all 16 bits of res_out are 0, for every code.
- R10: flags_out[0] equals res_out[15], for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First signed operand |
| b_in | input | 16 | Second signed operand |
| op_code | input | 3 | Operation code |
| res_out | output | 16 | Selected signed result |
| flags_out | output | 3 | {overflow, zero, negative} |

## Verification
The checker evaluates its properties whenever the combinational outputs change. It therefore assumes that every input is a known 0/1 value and that all three code bits change together. The bench drives only fully defined operands and codes, and it changes them all in one step one time unit after a clock edge. It compares the results half a period later, after the logic has settled. The stimulus includes the extreme values -32768, -1, 0 and 32767, so that each overflow boundary is met from both sides.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_MUL   = 3'b001,
    OP_PASSA = 3'b010,
    OP_PASSB = 3'b011,
    OP_SUB   = 3'b100
  } alu_op_e;

  // One bit of ripple addition: returns {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    return {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
  endfunction

  // Signed overflow of an adder: equal operand signs, differing result sign
  function automatic logic add_sign_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);

  logic [W-1:0] y_eff;
  logic [W:0]   carry;

  assign y_eff    = y_i ^ {W{sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] fa;
    assign fa         = full_add(x_i[i], y_eff[i], carry[i]);
    assign sum_o[i]   = fa[0];
    assign carry[i+1] = fa[1];
  end

  assign ovf_o = add_sign_ovf(x_i[W-1], y_eff[W-1], sum_o[W-1]);

endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] prod_o,
  output logic         ovf_o
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] full_prod;
  logic        [W:0]    upper;

  assign full_prod = PW'($signed(x_i)) * PW'($signed(y_i));
  assign prod_o    = full_prod[W-1:0];
  assign upper     = full_prod[PW-1:W-1];
  // the product fits only when the top W+1 bits are a pure sign extension
  assign ovf_o     = !((&upper) || !(|upper));

endmodule

// File: rtl/alu16_sel.sv
module alu16_sel
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] add_i,
  input  logic         add_ovf_i,
  input  logic [W-1:0] sub_i,
  input  logic         sub_ovf_i,
  input  logic [W-1:0] mul_i,
  input  logic         mul_ovf_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic [2:0]   flags_o
);

  logic ovf_sel;

  always_comb begin
    res_o   = '0;
    ovf_sel = 1'b0;
    case (op_i)
      OP_ADD:   begin res_o = add_i; ovf_sel = add_ovf_i; end
      OP_MUL:   begin res_o = mul_i; ovf_sel = mul_ovf_i; end
      OP_PASSA: res_o = a_i;
      OP_PASSB: res_o = b_i;
      OP_SUB:   begin res_o = sub_i; ovf_sel = sub_ovf_i; end
      default:  res_o = '0;
    endcase
  end

  assign flags_o = {ovf_sel, ~(|res_o), res_o[W-1]};

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op_code,
  output logic [W-1:0] res_out,
  output logic [2:0]   flags_out
);

  logic [W-1:0] add_res, sub_res, mul_res;
  logic         add_ovf, sub_ovf, mul_ovf;

  alu16_addsub #(.W(W)) u_add (
    .x_i(a_in), .y_i(b_in), .sub_i(1'b0), .sum_o(add_res), .ovf_o(add_ovf)
  );

  alu16_addsub #(.W(W)) u_sub (
    .x_i(a_in), .y_i(b_in), .sub_i(1'b1), .sum_o(sub_res), .ovf_o(sub_ovf)
  );

  alu16_mul #(.W(W)) u_mul (
    .x_i(a_in), .y_i(b_in), .prod_o(mul_res), .ovf_o(mul_ovf)
  );

  alu16_sel #(.W(W)) u_sel (
    .op_i(op_code),
    .add_i(add_res), .add_ovf_i(add_ovf),
    .sub_i(sub_res), .sub_ovf_i(sub_ovf),
    .mul_i(mul_res), .mul_ovf_i(mul_ovf),
    .a_i(a_in), .b_i(b_in),
    .res_o(res_out), .flags_o(flags_out)
  );

endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [2:0]   op_code,
  input logic [W-1:0] res_out,
  input logic [2:0]   flags_out,
  input logic         mul_ovf
);

  always_comb begin
    if (!$isunknown({a_in, b_in, op_code})) begin
      AST_ADD_RESULT: assert (op_code != 3'b000 || res_out == W'(a_in + b_in)); // R1
      AST_SUB_RESULT: assert (op_code != 3'b100 || res_out == W'(a_in - b_in)); // R2
      AST_PASS_RESULT: assert ((op_code != 3'b010 || res_out == a_in) && (op_code != 3'b011 || res_out == b_in)); // R4
      AST_UNDEF_ZERO: assert (op_code < 3'b101 || res_out == '0); // R5
      AST_MUL_OVF: assert (op_code != 3'b001 || flags_out[2] == mul_ovf); // R7
      AST_NO_OVERFLOW: assert (!(op_code == 3'b010 || op_code == 3'b011 || op_code >= 3'b101) || !flags_out[2]); // R8
      AST_ZERO_FLAG: assert (flags_out[1] == (res_out == '0)); // R9
      AST_NEG_FLAG: assert (flags_out[0] == res_out[W-1]); // R10
    end
  end

endmodule

bind alu16_flags alu16_flags_chk #(.W(W)) chk_i (
  .a_in(a_in), .b_in(b_in), .op_code(op_code),
  .res_out(res_out), .flags_out(flags_out), .mul_ovf(mul_ovf)
);

// File: tb/alu16_flags_tb_top.sv
module alu16_flags_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 10000;

  typedef struct {
    logic [15:0] r;
    logic [2:0]  f;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [2:0]  op_code = '0;
  logic [15:0] res_out;
  logic [2:0]  flags_out;

  int checks = 0, failures = 0;
  bit drive_done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_flags dut_i (
    .a_in(a_in), .b_in(b_in), .op_code(op_code),
    .res_out(res_out), .flags_out(flags_out)
  );

  // Reference model written with wide integer arithmetic
  function automatic exp_t model(input logic [2:0] op, input shortint a, input shortint b, input string tag);
    exp_t e;
    longint v;
    logic ov;
    ov = 1'b0;
    v  = 0;
    case (op)
      3'd0: begin v = longint'(a) + longint'(b); ov = (v > 32767) || (v < -32768); end
      3'd1: begin v = longint'(a) * longint'(b); ov = (v > 32767) || (v < -32768); end
      3'd2: v = longint'(a);
      3'd3: v = longint'(b);
      3'd4: begin v = longint'(a) - longint'(b); ov = (v > 32767) || (v < -32768); end
      default: v = 0;
    endcase
    e.r   = v[15:0];
    e.f   = {ov, (v[15:0] == 16'h0), v[15]};
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input shortint a, input shortint b, input string tag);
    @(posedge clk);
    #1;
    op_code = op;
    a_in    = a;
    b_in    = b;
    sb_q.push_back(model(op, a, b, tag));
  endtask

  // Monitor: compare one scoreboard item per cycle, mid-period
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (res_out !== e.r || flags_out !== e.f) begin
          failures++;
          $display("FAIL %s: op=%b a=%h b=%h got r=%h f=%b expected r=%h f=%b",
                   e.tag, op_code, a_in, b_in, res_out, flags_out, e.r, e.f);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!drive_done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!drive_done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // idle state: all-zero inputs, add code (R9 zero flag)
    drive(3'b000, 16'sd0, 16'sd0, "R1 R9");
    // R1 add
    drive(3'b000, 16'sd2, 16'sd2, "R1");
    drive(3'b000, 16'sd2, -16'sd2, "R1 R9");
    drive(3'b000, -16'sd2, -16'sd2, "R1 R10");
    // R6 add overflow boundaries
    drive(3'b000, -16'sd32768, -16'sd32768, "R6 R9");
    drive(3'b000, 16'sd32767, 16'sd1, "R6 R10");
    drive(3'b000, 16'sd32766, 16'sd1, "R6");
    drive(3'b000, -16'sd32767, -16'sd1, "R6");
    // R2 subtract
    drive(3'b100, 16'sd5, 16'sd7, "R2 R10");
    drive(3'b100, 16'sd100, 16'sd100, "R2 R9");
    drive(3'b100, -16'sd32768, 16'sd1, "R2 R6");
    drive(3'b100, 16'sd0, -16'sd32768, "R2 R6");
    drive(3'b100, -16'sd1, -16'sd32768, "R2 R6");
    // R3 multiply, R7 overflow
    drive(3'b001, 16'sd3, -16'sd7, "R3 R10");
    drive(3'b001, 16'sd181, 16'sd181, "R3 R7");
    drive(3'b001, 16'sd182, 16'sd182, "R3 R7");
    drive(3'b001, -16'sd32768, -16'sd1, "R3 R7");
    drive(3'b001, -16'sd32768, 16'sd1, "R3 R7");
    drive(3'b001, 16'sd256, 16'sd256, "R3 R7 R9");
    drive(3'b001, -16'sd256, 16'sd128, "R3 R7");
    drive(3'b001, -16'sd256, 16'sd129, "R3 R7");
    // R4 passthrough, R8 no overflow flag
    drive(3'b010, -16'sd1234, 16'sd55, "R4 R8");
    drive(3'b011, -16'sd1234, 16'sd55, "R4 R8");
    drive(3'b010, 16'sd0, -16'sd9, "R4 R9");
    drive(3'b011, -16'sd32768, -16'sd32768, "R4 R8");
    // R5 undefined codes give zero, no overflow
    drive(3'b101, -16'sd32768, -16'sd32768, "R5 R8 R9");
    drive(3'b110, 16'sd32767, 16'sd32767, "R5 R8");
    drive(3'b111, -16'sd1, 16'sd1, "R5 R8 R10");
    // sweep of all codes on one operand pair
    for (int k = 0; k < 8; k++) drive(3'(k), 16'sd30000, 16'sd20000, "R1 R2 R3 R4 R5");
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    drive_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule